// File: doc/BRIEF.md
# Multi-Stream Stride Prefetch Engine

This block sits beside one cache and watches its stream of miss line addresses. It keeps a small table of stream entries. Each entry learns a signed line stride from two nearby misses and becomes confirmed when a third miss lands exactly one stride further on. The stride can be +1, -1 or any other signed step. A confirmed stream that is hit by a demand miss starts a burst of prefetch line addresses. The burst walks forward from the missing line in steps of the stream's stride.

The number of prefetches in a burst is set at run time through `burst_limit`. Values above the build-time ceiling `MAX_BURST` are clamped, and a value of 0 turns issue off. Prefetches leave one per cycle on a valid/ready handshake. Any new miss ends the burst in progress. If that miss is itself a trigger, a fresh burst replaces the old one.

When every entry is in use, the least recently touched entry is overwritten.

The table has three entry states. `ST_ALLOC` means a single miss has been seen. `ST_TRAIN` means a stride has been learned. `ST_CONF` means the stream is confirmed. The transitions are:
- *pair*: `ST_ALLOC` to `ST_TRAIN`, on a nearby miss.
- *confirm*: `ST_TRAIN` to `ST_CONF`, on an exact stride match.
- *advance*: `ST_CONF` to `ST_CONF`, on an exact stride match.
- *allocate/replace*: any entry to `ST_ALLOC`, on a miss that matches nothing.

The issuer has two states, `BS_IDLE` and `BS_ISSUE`. Its transitions are:
- *launch*: `BS_IDLE` to `BS_ISSUE`, on a trigger with a non-zero limit.
- *drain*: `BS_ISSUE` to `BS_IDLE`, when the last request is accepted.
- *abort*: `BS_ISSUE` to `BS_IDLE`, on a non-trigger miss.
- *relaunch*: `BS_ISSUE` to `BS_ISSUE`, on a trigger miss.

Top module: `stride_prefetch_engine`

## Requirements
- R1: After reset, `pf_valid` is 0 and the table holds no streams.
- R2: A miss matching no stream allocates an entry and issues nothing. A later miss that differs from that entry's line by a non-zero amount of at most `PAIR_WIN` lines (default 64) sets the entry's stride to that difference and also issues nothing.
- R3: A miss equal to a trained entry's last line plus its stride confirms the stream. That miss, and every later miss that continues a confirmed stream, triggers a burst whose first address is the miss line plus the stride.
- R4: Within a burst, each address equals the previous one plus the stream's signed stride. This holds for +1, -1 and non-unit positive or negative strides.
- R5: A burst holds `min(burst_limit, MAX_BURST)` requests. `MAX_BURST` defaults to 25. A `burst_limit` of 0 gives no requests, although the stream is still updated.
- R6: At most one request is offered per cycle. A request that is not accepted keeps `pf_valid` high and `pf_addr` unchanged.
- R7: A miss that is not a trigger ends the current burst. `pf_valid` is 0 in the cycle after that miss.
- R8: A new stream takes a free entry if one exists. Otherwise it replaces the least recently allocated-or-matched entry, and the replaced stream no longer triggers.
- R9: `pf_valid` rises in the cycle right after a triggering miss, provided the limit is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_addr | input | ADDR_W | Line address of the miss |
| burst_limit | input | $clog2(MAX_BURST+1) | Requested prefetches per trigger; 0 disables |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | ADDR_W | Line address of the prefetch |

## Verification
The bench trains four streams with strides of +1, -1, +5 and -3. It checks the first burst address and every step of each burst, so a design that uses the wrong sign or an unsigned stride would produce a visibly diverging walk. A zero limit and an oversized limit are tried on a confirmed stream. These expose designs that issue while disabled or that fail to clamp at `MAX_BURST`. A stalled request and a miss that cuts a burst short check that the address holds under backpressure and that the abort takes effect one cycle later. Finally, the table is filled and then overflowed so that the stream recorded longest ago is the one lost. A design with the wrong replacement order would keep that stream alive and then prefetch for it.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        ST_ALLOC = 2'd0,
        ST_TRAIN = 2'd1,
        ST_CONF  = 2'd2
    } conf_e;

    typedef enum logic {
        BS_IDLE  = 1'b0,
        BS_ISSUE = 1'b1
    } burst_e;
endpackage

// File: rtl/spf_lru.sv
module spf_lru #(
    parameter int NUM_STREAMS = 8,
    localparam int IDX_W = $clog2(NUM_STREAMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0] age [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] is_oldest;

    // Ages form a permutation; 0 is newest, NUM_STREAMS-1 oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STREAMS; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                if (IDX_W'(i) == touch_idx)          age[i] <= '0;
                else if (age[i] < age[touch_idx])    age[i] <= age[i] + 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_old
            assign is_oldest[g] = (age[g] == IDX_W'(NUM_STREAMS - 1));
        end
    endgenerate

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < NUM_STREAMS; i++)
            if (is_oldest[i]) victim_idx = IDX_W'(i);
    end

    p_lru_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(is_oldest));
endmodule

// File: rtl/spf_stream_table.sv
module spf_stream_table
    import spf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_STREAMS = 8,
    parameter int STRIDE_W    = 16,
    parameter int PAIR_WIN    = 64,
    localparam int IDX_W = $clog2(NUM_STREAMS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                miss_valid,
    input  logic [ADDR_W-1:0]   miss_addr,
    input  logic [IDX_W-1:0]    victim_idx,
    output logic                touch,
    output logic [IDX_W-1:0]    touch_idx,
    output logic                trig,
    output logic [STRIDE_W-1:0] trig_stride
);
    localparam logic signed [ADDR_W-1:0] WIN_P = ADDR_W'(PAIR_WIN);
    localparam logic signed [ADDR_W-1:0] WIN_N = -WIN_P;

    logic                ent_valid  [NUM_STREAMS];
    conf_e               ent_state  [NUM_STREAMS];
    logic [ADDR_W-1:0]   ent_last   [NUM_STREAMS];
    logic [STRIDE_W-1:0] ent_stride [NUM_STREAMS];

    logic [NUM_STREAMS-1:0] exp_hit, near_hit, is_free;
    logic signed [ADDR_W-1:0] sdiff [NUM_STREAMS];

    generate
        for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_match
            logic [ADDR_W-1:0] pred;
            assign pred = ent_last[g]
                        + {{(ADDR_W-STRIDE_W){ent_stride[g][STRIDE_W-1]}}, ent_stride[g]};
            assign sdiff[g]    = $signed(miss_addr - ent_last[g]);
            assign exp_hit[g]  = ent_valid[g] && (ent_state[g] != ST_ALLOC)
                               && (miss_addr == pred);
            assign near_hit[g] = ent_valid[g] && (ent_state[g] == ST_ALLOC)
                               && (sdiff[g] != '0) && (sdiff[g] <= WIN_P)
                               && (sdiff[g] >= WIN_N);
            assign is_free[g]  = !ent_valid[g];
        end
    endgenerate

    logic             exp_any, near_any, free_any;
    logic [IDX_W-1:0] exp_idx, near_idx, free_idx, tgt_idx;

    // Lowest index wins within each class; stride match beats pairing.
    always_comb begin
        exp_any = 1'b0;  exp_idx  = '0;
        near_any = 1'b0; near_idx = '0;
        free_any = 1'b0; free_idx = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            if (exp_hit[i])  begin exp_any  = 1'b1; exp_idx  = IDX_W'(i); end
            if (near_hit[i]) begin near_any = 1'b1; near_idx = IDX_W'(i); end
            if (is_free[i])  begin free_any = 1'b1; free_idx = IDX_W'(i); end
        end
        if (exp_any)       tgt_idx = exp_idx;
        else if (near_any) tgt_idx = near_idx;
        else if (free_any) tgt_idx = free_idx;
        else               tgt_idx = victim_idx;
    end

    assign touch       = miss_valid;
    assign touch_idx   = tgt_idx;
    assign trig        = miss_valid && exp_any;
    assign trig_stride = ent_stride[exp_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                ent_valid[i]  <= 1'b0;
                ent_state[i]  <= ST_ALLOC;
                ent_last[i]   <= '0;
                ent_stride[i] <= '0;
            end
        end else if (miss_valid) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                if (IDX_W'(i) == tgt_idx) begin
                    ent_last[i] <= miss_addr;
                    if (exp_any) begin
                        ent_state[i] <= ST_CONF;       // confirm / advance
                    end else if (near_any) begin
                        ent_state[i]  <= ST_TRAIN;     // pair
                        ent_stride[i] <= sdiff[i][STRIDE_W-1:0];
                    end else begin
                        ent_valid[i]  <= 1'b1;         // allocate / replace
                        ent_state[i]  <= ST_ALLOC;
                        ent_stride[i] <= '0;
                    end
                end
            end
        end
    end

    p_trig_confirms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> ent_state[$past(tgt_idx)] == ST_CONF);
    p_pair_trains_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !exp_any && near_any) |=> ent_state[$past(tgt_idx)] == ST_TRAIN);
endmodule

// File: rtl/spf_burst_issuer.sv
module spf_burst_issuer
    import spf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int STRIDE_W  = 16,
    parameter int MAX_BURST = 25,
    localparam int LIM_W = $clog2(MAX_BURST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                miss_valid,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [STRIDE_W-1:0] start_stride,
    input  logic [LIM_W-1:0]    limit,
    output logic                pf_valid,
    input  logic                pf_ready,
    output logic [ADDR_W-1:0]   pf_addr
);
    burst_e              state_q, state_d;
    logic [ADDR_W-1:0]   next_q;
    logic [ADDR_W-1:0]   step_q;
    logic [LIM_W-1:0]    remain_q;
    logic [LIM_W-1:0]    lim_eff;
    logic [ADDR_W-1:0]   start_step;
    logic                launch;

    assign lim_eff    = (limit > LIM_W'(MAX_BURST)) ? LIM_W'(MAX_BURST) : limit;
    assign start_step = {{(ADDR_W-STRIDE_W){start_stride[STRIDE_W-1]}}, start_stride};
    assign launch     = start && (lim_eff != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE:  if (launch) state_d = BS_ISSUE;
            BS_ISSUE: begin
                if (miss_valid)                            state_d = launch ? BS_ISSUE : BS_IDLE;
                else if (pf_ready && remain_q == LIM_W'(1)) state_d = BS_IDLE;
            end
            default: state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BS_IDLE;
            next_q   <= '0;
            step_q   <= '0;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                next_q   <= start_addr + start_step;
                step_q   <= start_step;
                remain_q <= lim_eff;
            end else if (state_q == BS_ISSUE && pf_ready && !miss_valid) begin
                next_q   <= next_q + step_q;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    always_comb begin
        pf_valid = (state_q == BS_ISSUE);
        pf_addr  = next_q;
    end

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !miss_valid) |=> (pf_valid && $stable(pf_addr)));
    p_stop_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !start) |=> !pf_valid);
    p_remain_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (remain_q != '0 && remain_q <= LIM_W'(MAX_BURST)));
    p_launch_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit != '0) |=> pf_valid);
    p_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_valid && start && limit == '0) |=> !pf_valid);
endmodule

// File: rtl/stride_prefetch_engine.sv
module stride_prefetch_engine #(
    parameter int ADDR_W      = 32,
    parameter int NUM_STREAMS = 8,
    parameter int STRIDE_W    = 16,
    parameter int PAIR_WIN    = 64,
    parameter int MAX_BURST   = 25,
    localparam int LIM_W = $clog2(MAX_BURST + 1),
    localparam int IDX_W = $clog2(NUM_STREAMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [LIM_W-1:0]  burst_limit,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic                touch, trig;
    logic [IDX_W-1:0]    touch_idx, victim_idx;
    logic [STRIDE_W-1:0] trig_stride;

    spf_stream_table #(
        .ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS),
        .STRIDE_W(STRIDE_W), .PAIR_WIN(PAIR_WIN)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .victim_idx(victim_idx),
        .touch(touch), .touch_idx(touch_idx),
        .trig(trig), .trig_stride(trig_stride)
    );

    spf_lru #(.NUM_STREAMS(NUM_STREAMS)) i_lru (
        .clk(clk), .rst_n(rst_n),
        .touch(touch), .touch_idx(touch_idx),
        .victim_idx(victim_idx)
    );

    spf_burst_issuer #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .MAX_BURST(MAX_BURST)
    ) i_issuer (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .start(trig),
        .start_addr(miss_addr), .start_stride(trig_stride),
        .limit(burst_limit),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);
endmodule

// File: tb/test_stride_prefetch_engine.sv
module test_stride_prefetch_engine;
    localparam int AW = 32;
    localparam int LW = 5;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic [LW-1:0] burst_limit = '0;
    logic          pf_valid;
    logic          pf_ready = 1'b0;
    logic [AW-1:0] pf_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    stride_prefetch_engine i_stride_prefetch_engine (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .burst_limit(burst_limit), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr)
    );

    // miss line, limit, expected count, expected first address, expected step
    localparam int V_ADDR [NV] = '{32'h1000, 32'h1001, 32'h1002, 32'h1003,
                                   32'h5000, 32'h4FFF, 32'h4FFE,
                                   32'h9000, 32'h9005, 32'h900A,
                                   32'hC000, 32'hBFFD, 32'hBFFA,
                                   32'h900F, 32'h9014};
    localparam int V_LIM  [NV] = '{4, 4, 4, 6, 3, 3, 3, 5, 5, 5, 2, 2, 2, 0, 31};
    localparam int V_CNT  [NV] = '{0, 0, 4, 6, 0, 0, 3, 0, 0, 5, 0, 0, 2, 0, 25};
    localparam int V_FST  [NV] = '{0, 0, 32'h1003, 32'h1004, 0, 0, 32'h4FFD,
                                   0, 0, 32'h900F, 0, 0, 32'hBFF7, 0, 32'h9019};
    localparam int V_STP  [NV] = '{0, 0, 1, 1, 0, 0, -1, 0, 0, 5, 0, 0, -3, 0, 5};

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_miss(input int addr, input int lim, input bit rdy);
        @(negedge clk);
        miss_valid  = 1'b1;
        miss_addr   = AW'(addr);
        burst_limit = LW'(lim);
        pf_ready    = rdy;
        @(negedge clk);
        miss_valid  = 1'b0;
    endtask

    // Collect a burst with ready held high; first sample is one cycle after the miss.
    task automatic collect(input int exp_cnt, input int exp_first, input int exp_step,
                           input string req);
        int n = 0;
        logic [AW-1:0] prev = '0;
        bit first_seen = 1'b0;
        bit step_ok = 1'b1;
        bit first_ok = 1'b1;
        pf_ready = 1'b1;
        if (exp_cnt > 0)
            check(pf_valid === 1'b1, "R9", "valid right after trigger", pf_valid, 1);
        for (int c = 0; c < 32; c++) begin
            if (pf_valid) begin
                if (!first_seen) begin
                    first_ok = (pf_addr == AW'(exp_first));
                    if (!first_ok)
                        check(1'b0, req, "first address", pf_addr, exp_first);
                    first_seen = 1'b1;
                end else if (pf_addr != prev + AW'(exp_step)) begin
                    step_ok = 1'b0;
                    check(1'b0, "R4", "burst step", pf_addr, prev + AW'(exp_step));
                end
                prev = pf_addr;
                n++;
            end
            @(negedge clk);
        end
        check(n == exp_cnt, "R5", "burst count", n, exp_cnt);
        if (exp_cnt > 0 && first_ok && step_ok)
            check(1'b1, "R3", "first address and steps", 0, 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(pf_valid === 1'b0, "R1", "valid in reset", pf_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_valid === 1'b0, "R1", "valid after reset", pf_valid, 0);

        // Table walk: R2 training, R3 confirm, R4 strides, R5 limits, R9 latency
        for (int v = 0; v < NV; v++) begin
            send_miss(V_ADDR[v], V_LIM[v], 1'b1);
            collect(V_CNT[v], V_FST[v], V_STP[v], (V_CNT[v] == 0) ? "R2" : "R3");
        end

        // R7: a non-trigger miss cuts a running burst short
        send_miss(32'h1004, 6, 1'b1);
        pf_ready = 1'b1;
        check(pf_valid && pf_addr == 32'h1005, "R7", "burst start", pf_addr, 32'h1005);
        @(negedge clk);
        check(pf_valid && pf_addr == 32'h1006, "R6", "next per cycle", pf_addr, 32'h1006);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = 32'h20000; burst_limit = 5'd6; pf_ready = 1'b0;
        @(negedge clk);
        miss_valid = 1'b0;
        check(pf_valid === 1'b0, "R7", "valid after abort", pf_valid, 0);
        collect(0, 0, 0, "R7");

        // R8: fill the table, then overflow it
        send_miss(32'h30000, 2, 1'b1);
        send_miss(32'h40000, 2, 1'b1);
        send_miss(32'h50000, 2, 1'b1);
        send_miss(32'h60000, 2, 1'b1);  // replaces the descending stream
        send_miss(32'h4FFD, 2, 1'b1);   // replaced stream: no burst
        collect(0, 0, 0, "R8");

        // R6 backpressure and R8 survival of a recently used stream
        send_miss(32'h9019, 2, 1'b0);
        for (int c = 0; c < 3; c++) begin
            check(pf_valid === 1'b1 && pf_addr == 32'h901E, "R6", "stalled request held",
                  pf_addr, 32'h901E);
            @(negedge clk);
        end
        pf_ready = 1'b1;
        check(pf_valid === 1'b1 && pf_addr == 32'h901E, "R8", "kept stream fires",
              pf_addr, 32'h901E);
        @(negedge clk);
        check(pf_valid === 1'b1 && pf_addr == 32'h9023, "R4", "second after stall",
              pf_addr, 32'h9023);
        @(negedge clk);
        check(pf_valid === 1'b0, "R5", "burst of two ends", pf_valid, 0);

        send_miss(32'hBFF7, 2, 1'b1);   // second-oldest stream was replaced
        collect(0, 0, 0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule